// File: doc/BRIEF.md
# Split-Stream Dual Program Counter

This block produces the two fetch addresses of a processor whose code is held as two separate streams. One stream carries computation (arithmetic and logic) operations. The other carries control-flow and memory-access operations. Every redirect supplies one address, and that address is loaded into both counters. After that, the computation counter climbs toward higher addresses and the flow counter descends toward lower addresses. Each counter moves by the byte length of its own variable-length bundle. A downstream length decoder reports that length every cycle, together with an accept strobe for each stream.

A code block is entered only at its entry address and never falls through. If the block-end indication arrives without a redirect in the same cycle, the block raises a sticky fall-through error and freezes both counters. A call does not end a code block. The block saves both post-advance counters on an eight-entry return stack and restores them together on a return, so fetch resumes inside the calling block on both streams. Stack overflow and underflow are reported through sticky flags.

Top module: `dual_pc_seq`

## Requirements
- R1: A synchronous active-high reset sets both counters to the parameter RESET_ENTRY, empties the return stack and clears rs_ovf, rs_unf and fall_err.
- R2: When br_take is asserted and no call or return is asserted, both cmp_pc and flw_pc equal br_target after the next rising edge. Any advance requested in that cycle is ignored.
- R3: With no redirect and no blk_end, cmp_pc increases by cmp_len (1 to 32) on an edge where cmp_adv is high. It holds when cmp_adv is low. Arithmetic wraps modulo 2^32.
- R4: With no redirect and no blk_end, flw_pc decreases by flw_len (1 to 32) on an edge where flw_adv is high. It holds when flw_adv is low. Arithmetic wraps modulo 2^32.
- R5: The redirects are ranked as follows: ret_take has the highest priority, then call_take, then br_take, then the normal advance.
- R6: A call that wins arbitration loads both counters with call_target. It pushes the pair that would have resulted from this cycle's advance: cmp_pc plus cmp_len if cmp_adv is high, and flw_pc minus flw_len if flw_adv is high.
- R7: A return on a non-empty stack pops the most recently pushed pair and loads both counters from it in the same edge, in last-in first-out order.
- R8: A call made while 8 entries are held sets rs_ovf. The flag stays set until reset. The stack is left unchanged, but the counters still load call_target.
- R9: A return made on an empty stack sets rs_unf. The flag stays set until reset, and both counters hold their values.
- R10: blk_end asserted with no redirect sets fall_err. The flag stays set until reset, and both counters hold even if an advance is requested.
- R11: blk_end asserted together with any redirect raises no error, and the redirect takes effect normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_len | input | 6 | Byte length of the current computation bundle |
| cmp_adv | input | 1 | Computation bundle accepted this cycle |
| flw_len | input | 6 | Byte length of the current flow bundle |
| flw_adv | input | 1 | Flow bundle accepted this cycle |
| br_take | input | 1 | Taken branch |
| br_target | input | 32 | Branch target address |
| call_take | input | 1 | Call |
| call_target | input | 32 | Call target address |
| ret_take | input | 1 | Return |
| blk_end | input | 1 | Final bundle of the code block reached |
| cmp_pc | output | 32 | Computation-stream fetch address |
| flw_pc | output | 32 | Flow-stream fetch address |
| rs_ovf | output | 1 | Sticky return-stack overflow |
| rs_unf | output | 1 | Sticky return-stack underflow |
| fall_err | output | 1 | Sticky fall-through error |

## Verification
A corrupted stack pointer or a stale stack entry does not appear when it happens. It appears only at the matching return, when one or both counters reload an address other than the one saved at the call. The same fault can also appear as a false or missing overflow or underflow flag. For that reason the bench nests calls, returns with both streams advancing in between, and overfills and drains the stack. An adder with the wrong direction or width, or a broken priority, shows on cmp_pc or flw_pc at the very next edge. The bench compares every output against its reference model on every cycle.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    localparam int ADDR_W   = 32;
    localparam int LEN_W    = 6;
    localparam int RS_DEPTH = 8;
    localparam int RS_PTR_W = $clog2(RS_DEPTH);
    localparam int RS_CNT_W = $clog2(RS_DEPTH + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  blen_t;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_BRANCH,
        RD_CALL,
        RD_RETURN
    } redir_e;

    typedef struct packed {
        addr_t cmp;
        addr_t flw;
    } pc_pair_t;

    function automatic pc_pair_t both_at(addr_t a);
        pc_pair_t p;
        p.cmp = a;
        p.flw = a;
        return p;
    endfunction

endpackage

// File: rtl/dpc_step.sv
module dpc_step
    import dpc_pkg::*;
#(
    parameter bit DOWN = 1'b0
) (
    input  addr_t pc,
    input  blen_t len,
    input  logic  adv,
    output addr_t nxt
);
    addr_t delta;
    assign delta = adv ? addr_t'(len) : '0;

    generate
        if (DOWN) begin : g_down
            assign nxt = pc - delta;
        end else begin : g_up
            assign nxt = pc + delta;
        end
    endgenerate
endmodule

// File: rtl/dpc_redirect_arb.sv
module dpc_redirect_arb
    import dpc_pkg::*;
(
    input  logic   ret_take,
    input  logic   call_take,
    input  logic   br_take,
    output redir_e kind
);
    always_comb begin
        if (ret_take)       kind = RD_RETURN;
        else if (call_take) kind = RD_CALL;
        else if (br_take)   kind = RD_BRANCH;
        else                kind = RD_NONE;
    end
endmodule

// File: rtl/dpc_retstack.sv
module dpc_retstack
    import dpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  logic     pop,
    input  pc_pair_t push_data,
    output pc_pair_t top_data,
    output logic     empty,
    output logic     full
);
    pc_pair_t              mem [RS_DEPTH];
    logic [RS_CNT_W-1:0]   cnt;
    logic [RS_CNT_W-1:0]   top_ix;

    assign empty  = (cnt == '0);
    assign full   = (cnt == RS_CNT_W'(RS_DEPTH));
    assign top_ix = cnt - 1'b1;
    assign top_data = empty ? '0 : mem[top_ix[RS_PTR_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push && !full) begin
            cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && push && !full) begin
            mem[cnt[RS_PTR_W-1:0]] <= push_data;
        end
    end
endmodule

// File: rtl/dual_pc_seq.sv
module dual_pc_seq
    import dpc_pkg::*;
#(
    parameter logic [31:0] RESET_ENTRY = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  cmp_len,
    input  logic        cmp_adv,
    input  logic [5:0]  flw_len,
    input  logic        flw_adv,
    input  logic        br_take,
    input  logic [31:0] br_target,
    input  logic        call_take,
    input  logic [31:0] call_target,
    input  logic        ret_take,
    input  logic        blk_end,
    output logic [31:0] cmp_pc,
    output logic [31:0] flw_pc,
    output logic        rs_ovf,
    output logic        rs_unf,
    output logic        fall_err
);
    pc_pair_t cur, nxt, adv_pair, top_pair;
    redir_e   kind;
    logic     rs_empty, rs_full, do_push, do_pop;

    dpc_redirect_arb u_arb (
        .ret_take (ret_take),
        .call_take(call_take),
        .br_take  (br_take),
        .kind     (kind)
    );

    dpc_step #(.DOWN(1'b0)) u_cmp_step (
        .pc(cur.cmp), .len(cmp_len), .adv(cmp_adv), .nxt(adv_pair.cmp)
    );

    dpc_step #(.DOWN(1'b1)) u_flw_step (
        .pc(cur.flw), .len(flw_len), .adv(flw_adv), .nxt(adv_pair.flw)
    );

    assign do_push = (kind == RD_CALL) && !rs_full;
    assign do_pop  = (kind == RD_RETURN) && !rs_empty;

    dpc_retstack u_rs (
        .clk      (clk),
        .rst      (rst),
        .push     (do_push),
        .pop      (do_pop),
        .push_data(adv_pair),
        .top_data (top_pair),
        .empty    (rs_empty),
        .full     (rs_full)
    );

    always_comb begin
        nxt = cur;
        unique case (kind)
            RD_RETURN: if (!rs_empty) nxt = top_pair;
            RD_CALL:   nxt = both_at(call_target);
            RD_BRANCH: nxt = both_at(br_target);
            default:   if (!blk_end) nxt = adv_pair;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur      <= both_at(RESET_ENTRY);
            rs_ovf   <= 1'b0;
            rs_unf   <= 1'b0;
            fall_err <= 1'b0;
        end else begin
            cur <= nxt;
            if (kind == RD_CALL && rs_full)    rs_ovf   <= 1'b1;
            if (kind == RD_RETURN && rs_empty) rs_unf   <= 1'b1;
            if (kind == RD_NONE && blk_end)    fall_err <= 1'b1;
        end
    end

    assign cmp_pc = cur.cmp;
    assign flw_pc = cur.flw;
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker (
    input logic        clk,
    input logic        rst,
    input logic [5:0]  cmp_len,
    input logic        cmp_adv,
    input logic [5:0]  flw_len,
    input logic        flw_adv,
    input logic        br_take,
    input logic [31:0] br_target,
    input logic        call_take,
    input logic [31:0] call_target,
    input logic        ret_take,
    input logic        blk_end,
    input logic [31:0] cmp_pc,
    input logic [31:0] flw_pc,
    input logic        rs_ovf,
    input logic        rs_unf,
    input logic        fall_err
);
    logic quiet;
    assign quiet = !br_take && !call_take && !ret_take;

    AST_BRANCH_BOTH: assert property (@(posedge clk) disable iff (rst)
        (br_take && !call_take && !ret_take) |=>
        (cmp_pc == $past(br_target) && flw_pc == $past(br_target))); // R2

    AST_CMP_UP: assert property (@(posedge clk) disable iff (rst)
        (quiet && !blk_end) |=>
        (cmp_pc == $past(cmp_pc) + ($past(cmp_adv) ? 32'($past(cmp_len)) : 32'd0))); // R3

    AST_FLW_DOWN: assert property (@(posedge clk) disable iff (rst)
        (quiet && !blk_end) |=>
        (flw_pc == $past(flw_pc) - ($past(flw_adv) ? 32'($past(flw_len)) : 32'd0))); // R4

    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (rst)
        (call_take && !ret_take) |=>
        (cmp_pc == $past(call_target) && flw_pc == $past(call_target))); // R6

    AST_FALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (quiet && blk_end) |=> (fall_err && $stable(cmp_pc) && $stable(flw_pc))); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        rs_ovf |=> rs_ovf); // R8

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
        rs_unf |=> rs_unf); // R9

    AST_FALL_STICKY: assert property (@(posedge clk) disable iff (rst)
        fall_err |=> fall_err); // R10

    AST_END_REDIRECT_OK: assert property (@(posedge clk) disable iff (rst)
        (!fall_err && blk_end && !quiet) |=> !fall_err); // R11
endmodule

bind dual_pc_seq dpc_checker u_chk (
    .clk(clk), .rst(rst), .cmp_len(cmp_len), .cmp_adv(cmp_adv),
    .flw_len(flw_len), .flw_adv(flw_adv), .br_take(br_take),
    .br_target(br_target), .call_take(call_take), .call_target(call_target),
    .ret_take(ret_take), .blk_end(blk_end), .cmp_pc(cmp_pc), .flw_pc(flw_pc),
    .rs_ovf(rs_ovf), .rs_unf(rs_unf), .fall_err(fall_err)
);

// File: tb/tb_dual_pc_seq.sv
module tb_dual_pc_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ENTRY = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  cmp_len, flw_len;
    logic        cmp_adv, flw_adv, br_take, call_take, ret_take, blk_end;
    logic [31:0] br_target, call_target;
    logic [31:0] cmp_pc, flw_pc;
    logic        rs_ovf, rs_unf, fall_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pc_seq #(.RESET_ENTRY(ENTRY)) dut (
        .clk(clk), .rst(rst), .cmp_len(cmp_len), .cmp_adv(cmp_adv),
        .flw_len(flw_len), .flw_adv(flw_adv), .br_take(br_take),
        .br_target(br_target), .call_take(call_take), .call_target(call_target),
        .ret_take(ret_take), .blk_end(blk_end), .cmp_pc(cmp_pc), .flw_pc(flw_pc),
        .rs_ovf(rs_ovf), .rs_unf(rs_unf), .fall_err(fall_err)
    );

    // behavioural reference
    logic [31:0] m_cmp, m_flw;
    logic [63:0] m_stk[$];
    bit          m_ovf, m_unf, m_fall;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;
    string       tag = "R1";

    task automatic model_edge();
        logic [31:0] ac, af;
        ac = m_cmp + (cmp_adv ? 32'(cmp_len) : 32'd0);
        af = m_flw - (flw_adv ? 32'(flw_len) : 32'd0);
        if (rst) begin
            m_cmp = ENTRY; m_flw = ENTRY; m_stk.delete();
            m_ovf = 0; m_unf = 0; m_fall = 0;
        end else if (ret_take) begin
            if (m_stk.size() > 0) begin
                logic [63:0] e;
                e = m_stk.pop_back();
                m_cmp = e[63:32]; m_flw = e[31:0];
            end else m_unf = 1;
        end else if (call_take) begin
            if (m_stk.size() < 8) m_stk.push_back({ac, af});
            else m_ovf = 1;
            m_cmp = call_target; m_flw = call_target;
        end else if (br_take) begin
            m_cmp = br_target; m_flw = br_target;
        end else if (blk_end) begin
            m_fall = 1;
        end else begin
            m_cmp = ac; m_flw = af;
        end
    endtask

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("cmp_pc", cmp_pc, m_cmp);
        chk("flw_pc", flw_pc, m_flw);
        chk("rs_ovf", 32'(rs_ovf), 32'(m_ovf));
        chk("rs_unf", 32'(rs_unf), 32'(m_unf));
        chk("fall_err", 32'(fall_err), 32'(m_fall));
    endtask

    task automatic idle();
        rst = 0; cmp_adv = 0; flw_adv = 0; br_take = 0; call_take = 0;
        ret_take = 0; blk_end = 0; cmp_len = 6'd1; flw_len = 6'd1;
        br_target = '0; call_target = '0;
    endtask

    task automatic adv(int cl, int fl);
        idle();
        cmp_adv = (cl != 0); flw_adv = (fl != 0);
        cmp_len = 6'(cl); flw_len = 6'(fl);
        cyc();
    endtask

    task automatic do_reset();
        idle(); rst = 1; cyc(); cyc(); rst = 0;
    endtask

    initial begin
        idle();
        @(negedge clk);
        tag = "R1"; do_reset();
        idle(); cyc();

        tag = "R3"; adv(32, 0); adv(1, 0); adv(17, 0);
        tag = "R4"; adv(0, 32); adv(0, 1); adv(0, 9);
        adv(5, 12); adv(0, 0);

        tag = "R2";
        idle(); br_take = 1; br_target = 32'h0000_8000; cmp_adv = 1; cmp_len = 6'd8;
        flw_adv = 1; flw_len = 6'd4; cyc();
        adv(3, 7);
        tag = "R3"; idle(); br_take = 1; br_target = 32'hFFFF_FFF8; cyc(); adv(16, 0);
        tag = "R4"; idle(); br_take = 1; br_target = 32'h0000_0004; cyc(); adv(0, 20);

        tag = "R6";
        idle(); br_take = 1; br_target = 32'h0000_2000; cyc();
        idle(); call_take = 1; call_target = 32'h0000_5000; cmp_adv = 1; cmp_len = 6'd6;
        flw_adv = 1; flw_len = 6'd10; cyc();
        adv(4, 4);
        idle(); call_take = 1; call_target = 32'h0000_6000; cyc();
        adv(2, 3);
        tag = "R7";
        idle(); ret_take = 1; cyc();
        adv(1, 1);
        idle(); ret_take = 1; cyc();

        tag = "R5";
        idle(); call_take = 1; br_take = 1; call_target = 32'h0000_7000;
        br_target = 32'h0000_7777; cyc();
        idle(); ret_take = 1; call_take = 1; br_take = 1; call_target = 32'h1;
        br_target = 32'h2; cyc();
        idle(); ret_take = 1; br_take = 1; br_target = 32'h3; blk_end = 1; cyc();

        tag = "R9";
        idle(); ret_take = 1; cyc();
        idle(); ret_take = 1; cmp_adv = 1; cmp_len = 6'd4; cyc();
        adv(2, 2);

        tag = "R8";
        for (int i = 0; i < 9; i++) begin
            idle(); call_take = 1; call_target = 32'h0001_0000 + 32'(i * 256);
            cmp_adv = 1; cmp_len = 6'(i + 1); cyc();
        end
        tag = "R7";
        for (int i = 0; i < 9; i++) begin
            idle(); ret_take = 1; cyc();
        end

        tag = "R1"; do_reset(); idle(); cyc();

        tag = "R10";
        idle(); blk_end = 1; cmp_adv = 1; cmp_len = 6'd8; flw_adv = 1; flw_len = 6'd8; cyc();
        adv(4, 4);
        tag = "R1"; do_reset();
        tag = "R11";
        idle(); blk_end = 1; br_take = 1; br_target = 32'h0000_3000; cyc();
        idle(); blk_end = 1; call_take = 1; call_target = 32'h0000_3100; cyc();
        idle(); blk_end = 1; ret_take = 1; cyc();

        tag = "R5";
        for (int i = 0; i < 3000; i++) begin
            int r;
            idle();
            r = int'($urandom % 100);
            cmp_adv = $urandom % 4 != 0; flw_adv = $urandom % 3 != 0;
            cmp_len = 6'(1 + $urandom % 32); flw_len = 6'(1 + $urandom % 32);
            br_take = (r < 8); call_take = (r >= 8 && r < 14) || r == 50;
            ret_take = (r >= 14 && r < 20) || r == 50;
            blk_end = (r == 7) || (r == 30 && i % 5 == 0);
            br_target = $urandom; call_target = $urandom;
            if (i % 700 == 699) rst = 1;
            cyc();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule